// File: doc/BRIEF.md
# Decoder Picture Statistics Collector

This block watches the block-level event stream of a video decoder and builds per-picture quality figures from it. Each luma or chroma block arrives as a one-cycle strobe that carries its quantiser value, its size and three flags (intra, skipped, non-zero coefficients), plus a coded-block-pattern flag that can stand in for the non-zero flag. Each motion vector arrives as a strobe with signed X and Y components, the reference list it belongs to and its partition size. From these the block keeps weighted counts, quantiser sums, quantiser extremes, motion-vector sums and signed motion-vector extremes.

Software drives it through one control word and reads one 32-bit statistics word. The control word holds the mode bits, a clear command and a 5-bit index that picks which statistic the statistics word shows. The statistics word is registered, so it follows the index and the statistics one cycle later. A picture is typically handled by clearing, letting the decoder run, then stepping the index through all 21 slots.

Top module: `pic_stats_collector`

## Requirements
- R1: `cfg_rdata` returns bits 12:9 and 4:0 of the last written control word and zero in bits 8:5; after reset it reads 0. Bit 12 = coded-block-pattern select, bit 11 = absolute motion-vector mode, bit 10 = flat motion-vector weight, bit 9 = flat block weight, bit 8 = clear command, bits 4:0 = read index.
- R2: A control write with bit 8 set returns every statistic to its reset value at that clock edge; block or vector events in the same cycle are discarded, while the other fields of the written word take effect.
- R3: Index 0..4 read luma block count, luma QP sum, luma intra count, luma skipped count, luma non-zero count; index 5..9 the same for chroma (`blk_chroma`=1). A block of size code s (0=8x8, 1=16x16, 2=32x32, 3=64x64) weighs 4^s, or 1 when bit 9 is set; the QP sum adds QP times the weight.
- R4: The non-zero count (index 4 and 9) counts `blk_cbp` when control bit 12 is set and `blk_nz` otherwise.
- R5: Block counts and the vector count saturate at 2^20-1, the luma QP sum at 2^27-1 and the chroma QP sum at 2^26-1, never wrapping.
- R6: Index 10 reads {0, chroma QP max, 0, chroma QP min, 0, luma QP max, 0, luma QP min}, each QP 7 bits; after reset or clear the minima are 127 and the maxima 0 (reads 0x007F007F).
- R7: Index 11 reads the vector count: each vector of size code m (0=2x2 ... each step doubles the side) adds 4^m, or 1 when bit 10 is set.
- R8: The four 40-bit vector sums are kept in slot order k = 2*list + component (X L0, Y L0, X L1, Y L1). Each vector adds component times its weight (same weight as R7); with bit 11 clear the value is signed and the sum wraps modulo 2^40, with bit 11 set the magnitude is added and the sum saturates. Index 12 reads the upper 8 bits of the sums as {k3, k2, k1, k0}; index 13+k reads the low 32 bits of slot k.
- R9: Index 17+k reads {max, min} of slot k's component, each 16 bits in sign-magnitude form (bit 15 sign, bits 14:0 magnitude, -32768 shown as magnitude 32767); after reset or clear the read is 0xFFFF7FFF.
- R10: Index values 21..31 read zero.
- R11: `stat_rdata` is registered: the clock edge after the one that writes the index shows the new slot; in between it still shows the previous slot.
- R12: An event in the same cycle as a control write that changes mode bits is weighted with the mode in force before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 13 | Control word write data |
| cfg_rdata | output | 13 | Control word read back |
| stat_rdata | output | 32 | Statistic selected by the read index |
| blk_valid | input | 1 | Block event strobe |
| blk_chroma | input | 1 | 0 luma, 1 chroma |
| blk_size | input | 2 | Block size code |
| blk_qp | input | 7 | Block quantiser value |
| blk_intra | input | 1 | Block is intra coded |
| blk_skip | input | 1 | Block is skipped |
| blk_nz | input | 1 | Block has non-zero coefficients |
| blk_cbp | input | 1 | Coded-block-pattern flag of the block |
| mv_valid | input | 1 | Motion-vector event strobe |
| mv_list | input | 1 | Reference list (0 or 1) |
| mv_size | input | 3 | Partition size code |
| mv_x | input | 16 | X component, two's complement |
| mv_y | input | 16 | Y component, two's complement |

## Verification
Two functions can land on the same clock edge: a control write and a statistics update from a block or vector event. The bench provokes this by raising `cfg_wr` in the very cycle it strobes `blk_valid`, once with the clear bit set (the event must vanish and the counters read as cleared) and once with only the weighting bit flipped (the event must carry the old weight and the next event the new one). A third overlap, an index change while the registered readout still holds the old slot, is judged by sampling `stat_rdata` both one and two edges after the write.

// File: rtl/pic_stats_collector.sv
module pic_stats_collector #(
  parameter int CNT_W = 20,
  parameter int YQP_W = 27,
  parameter int CQP_W = 26
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [12:0] cfg_wdata,
  output logic [12:0] cfg_rdata,
  output logic [31:0] stat_rdata,
  input  logic        blk_valid,
  input  logic        blk_chroma,
  input  logic [1:0]  blk_size,
  input  logic [6:0]  blk_qp,
  input  logic        blk_intra,
  input  logic        blk_skip,
  input  logic        blk_nz,
  input  logic        blk_cbp,
  input  logic        mv_valid,
  input  logic        mv_list,
  input  logic [2:0]  mv_size,
  input  logic [15:0] mv_x,
  input  logic [15:0] mv_y
);
  localparam int ACC_W = (YQP_W > CQP_W) ? YQP_W : CQP_W;
  localparam logic [39:0] CNT_LIM = 40'((41'd1 << CNT_W) - 41'd1);
  localparam logic [39:0] YQP_LIM = 40'((41'd1 << YQP_W) - 41'd1);
  localparam logic [39:0] CQP_LIM = 40'((41'd1 << CQP_W) - 41'd1);
  localparam logic [39:0] SUM_LIM = {40{1'b1}};

  logic [12:0]      cfg;
  logic [ACC_W-1:0] acc   [10];
  logic [39:0]      binc  [10];
  logic [6:0]       qmin  [2];
  logic [6:0]       qmax  [2];
  logic [CNT_W-1:0] mvcnt;
  logic [39:0]      mvsum [4];
  logic [15:0]      mvmax [4];
  logic [15:0]      mvmin [4];
  logic [15:0]      mvc   [2];
  logic [39:0]      mvterm[2];
  logic [31:0]      rd_next;

  wire       clr = cfg_wr & cfg_wdata[8];
  wire [4:0] idx = cfg[4:0];
  wire [3:0] bsh = cfg[9]  ? 4'd0 : {1'b0, blk_size, 1'b0};
  wire [3:0] msh = cfg[10] ? 4'd0 : {mv_size, 1'b0};
  wire [39:0] bw = 40'd1 << bsh;
  wire [39:0] mw = 40'd1 << msh;
  wire       nzf = cfg[12] ? blk_cbp : blk_nz;
  wire       unused_rsvd = ^cfg_wdata[7:5];

  assign cfg_rdata = cfg;
  assign mvc[0] = mv_x;
  assign mvc[1] = mv_y;

  function automatic logic [39:0] sat_add(input logic [39:0] a, input logic [39:0] b,
                                          input logic [39:0] lim);
    logic [40:0] s;
    s = {1'b0, a} + {1'b0, b};
    return (s > {1'b0, lim}) ? lim : s[39:0];
  endfunction

  function automatic logic [39:0] lim_of(input int i);
    case (i)
      1:       return YQP_LIM;
      6:       return CQP_LIM;
      default: return CNT_LIM;
    endcase
  endfunction

  function automatic logic [15:0] sm(input logic [15:0] v);
    if (!v[15])            return v;
    else if (v == 16'h8000) return 16'hFFFF;
    else                   return {1'b1, 15'(-v)};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) cfg <= '0;
    else if (cfg_wr) cfg <= {cfg_wdata[12:9], 4'b0000, cfg_wdata[4:0]};
  end

  always_comb begin
    int b;
    b = blk_chroma ? 5 : 0;
    for (int i = 0; i < 10; i++) binc[i] = '0;
    binc[b]     = bw;
    binc[b + 1] = 40'(blk_qp) << bsh;
    binc[b + 2] = blk_intra ? bw : 40'd0;
    binc[b + 3] = blk_skip  ? bw : 40'd0;
    binc[b + 4] = nzf       ? bw : 40'd0;
  end

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      if (cfg[11])
        mvterm[c] = 40'(mvc[c][15] ? 16'(-mvc[c]) : mvc[c]) << msh;
      else
        mvterm[c] = 40'($signed(mvc[c])) << msh;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      for (int i = 0; i < 10; i++) acc[i] <= '0;
      for (int q = 0; q < 2; q++) begin
        qmin[q] <= 7'h7F;
        qmax[q] <= 7'h00;
      end
      mvcnt <= '0;
      for (int k = 0; k < 4; k++) begin
        mvsum[k] <= '0;
        mvmax[k] <= 16'h8000;
        mvmin[k] <= 16'h7FFF;
      end
    end else begin
      if (blk_valid) begin
        for (int i = 0; i < 10; i++)
          acc[i] <= ACC_W'(sat_add(40'(acc[i]), binc[i], lim_of(i)));
        if (blk_qp < qmin[blk_chroma]) qmin[blk_chroma] <= blk_qp;
        if (blk_qp > qmax[blk_chroma]) qmax[blk_chroma] <= blk_qp;
      end
      if (mv_valid) begin
        mvcnt <= CNT_W'(sat_add(40'(mvcnt), mw, CNT_LIM));
        for (int c = 0; c < 2; c++) begin
          if (cfg[11])
            mvsum[{mv_list, 1'(c)}] <= sat_add(mvsum[{mv_list, 1'(c)}], mvterm[c], SUM_LIM);
          else
            mvsum[{mv_list, 1'(c)}] <= mvsum[{mv_list, 1'(c)}] + mvterm[c];
          if ($signed(mvc[c]) > $signed(mvmax[{mv_list, 1'(c)}]))
            mvmax[{mv_list, 1'(c)}] <= mvc[c];
          if ($signed(mvc[c]) < $signed(mvmin[{mv_list, 1'(c)}]))
            mvmin[{mv_list, 1'(c)}] <= mvc[c];
        end
      end
    end
  end

  always_comb begin
    rd_next = '0;
    case (idx)
      5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd6, 5'd7, 5'd8, 5'd9:
        rd_next = 32'(acc[idx]);
      5'd10: rd_next = {1'b0, qmax[1], 1'b0, qmin[1], 1'b0, qmax[0], 1'b0, qmin[0]};
      5'd11: rd_next = 32'(mvcnt);
      5'd12: rd_next = {mvsum[3][39:32], mvsum[2][39:32], mvsum[1][39:32], mvsum[0][39:32]};
      5'd13, 5'd14, 5'd15, 5'd16:
        rd_next = mvsum[2'(idx - 5'd13)][31:0];
      5'd17, 5'd18, 5'd19, 5'd20:
        rd_next = {sm(mvmax[2'(idx - 5'd17)]), sm(mvmin[2'(idx - 5'd17)])};
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stat_rdata <= '0;
    else        stat_rdata <= rd_next;
  end

  // R1
  cfg_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> cfg_rdata == {$past(cfg_wdata[12:9]), 4'b0000, $past(cfg_wdata[4:0])});

  // R2
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc[0] == '0 && acc[5] == '0 && mvcnt == '0 && qmin[0] == 7'h7F && mvsum[0] == '0));

  // R5
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (acc[0] >= $past(acc[0]) && acc[1] >= $past(acc[1]) && mvcnt >= $past(mvcnt)));

  // R6
  qp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid && !blk_chroma && !clr) |=> (qmax[0] >= $past(blk_qp) && qmin[0] <= $past(blk_qp)));

  // R9
  mv_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_valid && !mv_list && !clr) |=>
      ($signed(mvmax[0]) >= $signed($past(mv_x)) && $signed(mvmin[0]) <= $signed($past(mv_x))));

  // R10
  idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idx > 5'd20) |=> stat_rdata == 32'd0);
endmodule

// File: tb/pic_stats_collector_test.sv
`timescale 1ns/1ps
module pic_stats_collector_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [12:0] cfg_wdata = '0;
  logic [12:0] cfg_rdata;
  logic [31:0] stat_rdata;
  logic        blk_valid = 1'b0, blk_chroma = 1'b0;
  logic [1:0]  blk_size = '0;
  logic [6:0]  blk_qp = '0;
  logic        blk_intra = 1'b0, blk_skip = 1'b0, blk_nz = 1'b0, blk_cbp = 1'b0;
  logic        mv_valid = 1'b0, mv_list = 1'b0;
  logic [2:0]  mv_size = '0;
  logic [15:0] mv_x = '0, mv_y = '0;

  int errors = 0;
  int checks = 0;

  longint      m_acc [10];
  int          m_qmin[2], m_qmax[2];
  longint      m_mvc;
  logic [39:0] m_s   [4];
  int          m_max [4], m_min[4];
  logic [12:0] m_cfg;

  localparam longint CNTL = (64'd1 << 20) - 1;
  localparam longint SUML = (64'd1 << 40) - 1;

  always #5 clk = ~clk;

  pic_stats_collector uut (.*);

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic longint limf(int i);
    if (i == 1) return (64'd1 << 27) - 1;
    if (i == 6) return (64'd1 << 26) - 1;
    return CNTL;
  endfunction

  function automatic longint smin(longint a, longint b);
    return (a < b) ? a : b;
  endfunction

  function automatic logic [15:0] smf(int v);
    if (v >= 0) return 16'(v);
    return 16'(32768 + ((-v > 32767) ? 32767 : -v));
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 10; i++) m_acc[i] = 0;
    for (int q = 0; q < 2; q++) begin m_qmin[q] = 127; m_qmax[q] = 0; end
    m_mvc = 0;
    for (int k = 0; k < 4; k++) begin m_s[k] = '0; m_max[k] = -32768; m_min[k] = 32767; end
  endtask

  task automatic model_blk(int ch, int sz, int qp, bit it, bit sk, bit nz, bit cb);
    longint w = m_cfg[9] ? 1 : (64'd1 << (2 * sz));
    int b = ch ? 5 : 0;
    bit nzs = m_cfg[12] ? cb : nz;
    m_acc[b]   = smin(m_acc[b] + w, limf(b));
    m_acc[b+1] = smin(m_acc[b+1] + qp * w, limf(b+1));
    if (it)  m_acc[b+2] = smin(m_acc[b+2] + w, limf(b+2));
    if (sk)  m_acc[b+3] = smin(m_acc[b+3] + w, limf(b+3));
    if (nzs) m_acc[b+4] = smin(m_acc[b+4] + w, limf(b+4));
    if (qp < m_qmin[ch]) m_qmin[ch] = qp;
    if (qp > m_qmax[ch]) m_qmax[ch] = qp;
  endtask

  task automatic model_mv(int lst, int sz, int x, int y);
    longint w = m_cfg[10] ? 1 : (64'd1 << (2 * sz));
    m_mvc = smin(m_mvc + w, CNTL);
    for (int c = 0; c < 2; c++) begin
      int v = c ? y : x;
      int k = lst * 2 + c;
      if (m_cfg[11]) begin
        longint a = (v < 0 ? -v : v) * w;
        m_s[k] = 40'(smin(longint'(m_s[k]) + a, SUML));
      end else begin
        m_s[k] = m_s[k] + 40'(longint'(v) * w);
      end
      if (v > m_max[k]) m_max[k] = v;
      if (v < m_min[k]) m_min[k] = v;
    end
  endtask

  function automatic logic [31:0] expv(int i);
    if (i <= 9) return 32'(m_acc[i]);
    if (i == 10) return {1'b0, 7'(m_qmax[1]), 1'b0, 7'(m_qmin[1]), 1'b0, 7'(m_qmax[0]), 1'b0, 7'(m_qmin[0])};
    if (i == 11) return 32'(m_mvc);
    if (i == 12) return {m_s[3][39:32], m_s[2][39:32], m_s[1][39:32], m_s[0][39:32]};
    if (i <= 16) return m_s[i-13][31:0];
    if (i <= 20) return {smf(m_max[i-17]), smf(m_min[i-17])};
    return 32'd0;
  endfunction

  function automatic string tag_of(int i);
    if (i == 4 || i == 9) return "R4";
    if (i <= 9)  return "R3";
    if (i == 10) return "R6";
    if (i == 11) return "R7";
    if (i <= 16) return "R8";
    if (i <= 20) return "R9";
    return "R10";
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic blk(int ch, int sz, int qp, bit it, bit sk, bit nz, bit cb);
    blk_valid = 1'b1; blk_chroma = 1'(ch); blk_size = 2'(sz); blk_qp = 7'(qp);
    blk_intra = it; blk_skip = sk; blk_nz = nz; blk_cbp = cb;
    model_blk(ch, sz, qp, it, sk, nz, cb);
    @(negedge clk);
    blk_valid = 1'b0;
  endtask

  task automatic mv(int lst, int sz, int x, int y);
    mv_valid = 1'b1; mv_list = 1'(lst); mv_size = 3'(sz); mv_x = 16'(x); mv_y = 16'(y);
    model_mv(lst, sz, x, y);
    @(negedge clk);
    mv_valid = 1'b0;
  endtask

  task automatic cfgw(logic [12:0] w);
    cfg_wr = 1'b1; cfg_wdata = w;
    if (w[8]) model_clear();
    m_cfg = w & 13'h1E1F;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(string tag, int i);
    cfgw((m_cfg & 13'h1E00) | 13'(i));
    @(negedge clk);
    check(tag, stat_rdata, expv(i));
  endtask

  task automatic blk_sweep();
    for (int ch = 0; ch < 2; ch++)
      for (int sz = 0; sz < 4; sz++)
        for (int f = 0; f < 16; f++)
          blk(ch, sz, (ch * 37 + sz * 11 + f * 5 + 3) % 128, f[0], f[1], f[2], f[3]);
    blk(0, 1, 0, 1'b0, 1'b0, 1'b1, 1'b0);
    blk(1, 0, 127, 1'b1, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic mv_sweep();
    int vals[8] = '{0, 1, -1, 5, -300, 32767, -32768, 1234};
    for (int l = 0; l < 2; l++)
      for (int sz = 0; sz < 8; sz++)
        for (int j = 0; j < 8; j++)
          mv(l, sz, vals[j], vals[(j + 3 + sz) % 8]);
  endtask

  initial begin
    m_cfg = '0;
    model_clear();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check("R1 reset cfg", 32'(cfg_rdata), 32'd0);
    check("R3 reset count", stat_rdata, 32'd0);
    rd("R6 reset qp extremes", 10);
    rd("R9 reset mv extremes", 17);
    rd("R8 reset mv sums", 12);

    cfgw(13'h0000);
    blk_sweep();
    for (int i = 0; i <= 11; i++) rd(tag_of(i), i);

    cfgw(13'h1200);
    blk_sweep();
    for (int i = 0; i <= 10; i++) rd(tag_of(i), i);

    cfgw(13'h0100);
    mv_sweep();
    for (int i = 11; i <= 31; i++) rd(tag_of(i), i);

    cfgw(13'h0D00);
    mv_sweep();
    for (int i = 11; i <= 20; i++) rd(tag_of(i), i);

    // R11: registered readout latency
    rd("R11 before", 0);
    cfg_wr = 1'b1; cfg_wdata = (m_cfg & 13'h1E00) | 13'd11;
    @(negedge clk);
    cfg_wr = 1'b0; m_cfg = cfg_wdata;
    check("R11 old slot held", stat_rdata, expv(0));
    @(negedge clk);
    check("R11 new slot", stat_rdata, expv(11));

    // R2: clear in the same cycle as a block event
    cfgw(13'h0000);
    blk(0, 2, 50, 1'b1, 1'b1, 1'b1, 1'b1);
    blk_valid = 1'b1; blk_chroma = 1'b0; blk_size = 2'd3; blk_qp = 7'd9;
    blk_intra = 1'b1; blk_skip = 1'b1; blk_nz = 1'b1; blk_cbp = 1'b1;
    cfg_wr = 1'b1; cfg_wdata = 13'h1FFF;
    model_clear();
    m_cfg = 13'h1E1F;
    @(negedge clk);
    blk_valid = 1'b0; cfg_wr = 1'b0;
    check("R1 readback reserved zero", 32'(cfg_rdata), 32'h1E1F);
    @(negedge clk);
    check("R10 index 31", stat_rdata, 32'd0);
    rd("R2 count cleared", 0);
    rd("R2 qp sum cleared", 1);
    rd("R2 qp extremes cleared", 10);
    rd("R2 mv sum cleared", 13);

    // R12: mode write collides with a block event
    cfgw(13'h0000);
    blk_valid = 1'b1; blk_chroma = 1'b0; blk_size = 2'd2; blk_qp = 7'd4;
    blk_intra = 1'b0; blk_skip = 1'b0; blk_nz = 1'b0; blk_cbp = 1'b0;
    model_blk(0, 2, 4, 1'b0, 1'b0, 1'b0, 1'b0);
    cfg_wr = 1'b1; cfg_wdata = 13'h0200;
    @(negedge clk);
    blk_valid = 1'b0; cfg_wr = 1'b0; m_cfg = 13'h0200;
    rd("R12 old weight used", 0);
    check("R12 weight 16", 32'(m_acc[0]), 32'd16);
    blk(0, 2, 4, 1'b0, 1'b0, 1'b0, 1'b0);
    rd("R12 new weight used", 0);

    // R5: saturation
    cfgw(13'h0100);
    for (int n = 0; n < 16600; n++) begin
      blk(0, 3, 127, 1'b1, 1'b1, 1'b1, 1'b0);
      blk(1, 3, 127, 1'b1, 1'b0, 1'b1, 1'b0);
    end
    for (int i = 0; i <= 9; i++) rd("R5", i);
    check("R5 luma count limit", 32'(m_acc[0]), 32'hFFFFF);
    for (int n = 0; n < 70; n++) mv(0, 7, -7, 3);
    rd("R5 vector count limit", 11);
    rd("R8 signed sum", 13);
    rd("R9 extremes", 17);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule